// File: doc/BRIEF.md
# Serial CRC-16 Frame Checker with Single-Bit Repair

This block takes in a fixed-length frame one bit per clock, rebuilds the CRC of the payload as the bits arrive, and compares it with the check word that ends the frame. A frame holds 128 payload bits followed by a 16-bit check word, and both are sent most significant bit first. When the two CRC values disagree, their XOR (the syndrome) is compared against the syndrome that a flip at each of the 144 frame positions would cause. A match tells the block which bit to invert.

The result is given in parallel in the cycle after the final bit. It consists of the 128-bit payload, repaired if needed, and a one-cycle completion pulse with exactly one of four outcome flags: clean, payload repaired, check-word error only, or uncorrectable. The block is placed behind a serial receiver where errors are rare and a retry costs too much.

Top module: `crc_bitfix`

## Requirements
- R1: While rst_ni is low, and after it is released, data_o and all the flags are zero until the first frame completes.
- R2: A frame begins on a cycle where bit_valid_i and frame_start_i are both high. That bit is frame position 0. Positions 0..127 are payload bits, MSB first, so position 0 lands in data_o[127]. Positions 128..143 are the received check word, MSB first. Cycles with bit_valid_i low stall the frame. Valid bits that arrive while no frame is open and frame_start_i is low are ignored.
- R3: The CRC uses generator x^16+x^15+x^2+1 (0x8005). It starts from all zeros at each frame start, takes in payload bits MSB first, and has no final inversion.
- R4: done_o is high for exactly one cycle: the cycle after the clock edge that samples frame position 143. With it, exactly one of ok_o, corrected_o, chk_err_o and uncorr_o is high. All the flags are low whenever done_o is low.
- R5: If the recomputed CRC equals the received check word, ok_o is raised and data_o equals the received payload.
- R6: If exactly one payload bit is flipped, corrected_o is raised and data_o equals the original payload.
- R7: If exactly one check-word bit is flipped, chk_err_o is raised and data_o equals the received payload unchanged.
- R8: A nonzero syndrome that matches no single-position pattern raises uncorr_o, and data_o equals the received payload unchanged.
- R9: Any two-bit error raises uncorr_o and is never repaired. Any odd number of bit errors never raises ok_o.
- R10: A frame_start_i with bit_valid_i in the middle of a frame drops the partial frame and opens a new one at position 0. No done_o is produced for the dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks frame position 0 when bit_valid_i is high |
| bit_valid_i | input | 1 | bit_i carries a frame bit this cycle |
| bit_i | input | 1 | Serial frame bit |
| data_o | output | 128 | Payload, repaired when a single payload bit was wrong |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Frame was clean |
| corrected_o | output | 1 | One payload bit was inverted |
| chk_err_o | output | 1 | Single error located in the check word |
| uncorr_o | output | 1 | Error cannot be located |

## Verification
The assertions check four things on every cycle. The completion pulse lasts one cycle, and exactly one outcome flag comes with it. At most one position pattern matches the syndrome. The output differs from the received payload by exactly one bit when a repair is reported, and by no bit otherwise. Only the bench scenarios can show that the repaired bit is the right one, that every one of the 144 positions is classified correctly, that two-bit errors never alias to a repair, and that stalls, stray bits and restarts leave the result intact. The bench checks these against a brute-force flip-and-recheck model.

// File: rtl/crc_bitfix_pkg.sv
package crc_bitfix_pkg;
  typedef enum logic [1:0] {
    FX_CLEAN = 2'd0,
    FX_DATA  = 2'd1,
    FX_CHECK = 2'd2,
    FX_BAD   = 2'd3
  } fix_kind_e;
endpackage

// File: rtl/crc_bitfix_lfsr.sv
module crc_bitfix_lfsr #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, base, nxt;
  logic             fb;

  always_comb begin
    base = clr_i ? '0 : crc_q;
    fb   = base[CRC_W-1] ^ bit_i;
    nxt  = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= nxt;
  end

  assign crc_o = crc_q;

  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_o)); // R3
endmodule

// File: rtl/crc_bitfix_locate.sv
module crc_bitfix_locate #(
  parameter int               DATA_W = 128,
  parameter int               CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = 16'h8005,
  localparam int              FRAME_W = DATA_W + CRC_W,
  localparam int              POS_W   = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CRC_W-1:0] syn_i,
  output logic             hit_o,
  output logic [POS_W-1:0] pos_o
);
  // x^k mod g: syndrome of a flip k positions before the frame end
  function automatic logic [CRC_W-1:0] xpow(input int k);
    logic [CRC_W-1:0] r;
    r = {{(CRC_W-1){1'b0}}, 1'b1};
    for (int i = 0; i < k; i++)
      r = {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? POLY : '0);
    return r;
  endfunction

  logic [FRAME_W-1:0] hit;

  for (genvar p = 0; p < FRAME_W; p++) begin : g_pat
    localparam logic [CRC_W-1:0] PAT = xpow(FRAME_W - 1 - p);
    assign hit[p] = (syn_i == PAT);
  end

  always_comb begin
    pos_o = '0;
    for (int p = 0; p < FRAME_W; p++)
      if (hit[p]) pos_o = pos_o | POS_W'(p);
  end

  assign hit_o = |hit;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R6
endmodule

// File: rtl/crc_bitfix.sv
module crc_bitfix #(
  parameter int               DATA_W = 128,
  parameter int               CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = 16'h8005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              corrected_o,
  output logic              chk_err_o,
  output logic              uncorr_o
);
  import crc_bitfix_pkg::*;

  localparam int FRAME_W = DATA_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic              act_q;
  logic [CNT_W-1:0]  cnt_q, pos;
  logic              take, in_data, last;
  logic [DATA_W-1:0] data_q, flip_mask;
  logic [CRC_W-1:0]  rxc_q, rxc_full, crc, syn;
  logic              hit;
  logic [CNT_W-1:0]  hit_pos, flip_idx;
  fix_kind_e         kind, kind_q;
  logic              done_q;

  assign take    = bit_valid_i && (frame_start_i || act_q);
  assign pos     = frame_start_i ? '0 : cnt_q;
  assign in_data = take && (pos < CNT_W'(DATA_W));
  assign last    = take && (pos == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (take) begin
      act_q <= !last;
      cnt_q <= last ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rxc_q  <= '0;
    end else if (in_data) begin
      data_q <= {data_q[DATA_W-2:0], bit_i};
    end else if (take) begin
      rxc_q  <= {rxc_q[CRC_W-2:0], bit_i};
    end
  end

  crc_bitfix_lfsr #(.CRC_W(CRC_W), .POLY(POLY)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_data),
    .clr_i  (frame_start_i),
    .bit_i  (bit_i),
    .crc_o  (crc)
  );

  // last check bit joins the syndrome straight from the pin
  assign rxc_full = {rxc_q[CRC_W-2:0], bit_i};
  assign syn      = crc ^ rxc_full;

  crc_bitfix_locate #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_loc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .syn_i  (syn),
    .hit_o  (hit),
    .pos_o  (hit_pos)
  );

  always_comb begin
    if (syn == '0)                        kind = FX_CLEAN;
    else if (!hit)                        kind = FX_BAD;
    else if (hit_pos < CNT_W'(DATA_W))    kind = FX_DATA;
    else                                  kind = FX_CHECK;
  end

  assign flip_idx  = CNT_W'(DATA_W - 1) - hit_pos;
  assign flip_mask = {{(DATA_W-1){1'b0}}, 1'b1} << flip_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      kind_q <= FX_CLEAN;
      data_o <= '0;
    end else begin
      done_q <= last;
      if (last) begin
        kind_q <= kind;
        data_o <= (kind == FX_DATA) ? (data_q ^ flip_mask) : data_q;
      end
    end
  end

  assign done_o      = done_q;
  assign ok_o        = done_q && (kind_q == FX_CLEAN);
  assign corrected_o = done_q && (kind_q == FX_DATA);
  assign chk_err_o   = done_q && (kind_q == FX_CHECK);
  assign uncorr_o    = done_q && (kind_q == FX_BAD);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({ok_o, corrected_o, chk_err_o, uncorr_o}) == 1); // R4
  AST_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(ok_o || corrected_o || chk_err_o || uncorr_o)); // R4
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !corrected_o |-> data_o == data_q); // R7
  AST_FIX_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corrected_o |-> $countones(data_o ^ data_q) == 1); // R6
endmodule

// File: tb/sim_crc_bitfix.sv
module sim_crc_bitfix;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;
  localparam int CW = 16;
  localparam int FW = DW + CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, bin = 1'b0;
  logic [DW-1:0] data_o;
  logic done_o, ok_o, corrected_o, chk_err_o, uncorr_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_bitfix u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(start), .bit_valid_i(valid),
    .bit_i(bin), .data_o(data_o), .done_o(done_o), .ok_o(ok_o),
    .corrected_o(corrected_o), .chk_err_o(chk_err_o), .uncorr_o(uncorr_o));

  function automatic logic [CW-1:0] ref_crc(input logic [DW-1:0] d);
    logic [CW-1:0] r = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      logic fb;
      fb = r[CW-1] ^ d[i];
      r  = {r[CW-2:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic bit frame_good(input logic [FW-1:0] f);
    return ref_crc(f[FW-1:CW]) == f[CW-1:0];
  endfunction

  // brute force: flip each position and recheck; 0 clean 1 data 2 check 3 bad
  function automatic int classify(input logic [FW-1:0] f, output logic [DW-1:0] d);
    d = f[FW-1:CW];
    if (frame_good(f)) return 0;
    for (int i = 0; i < FW; i++) begin
      logic [FW-1:0] g;
      g = f;
      g[i] = ~g[i];
      if (frame_good(g)) begin
        if (i >= CW) begin d = g[FW-1:CW]; return 1; end
        return 2;
      end
    end
    return 3;
  endfunction

  function automatic logic [FW-1:0] rand_frame();
    logic [DW-1:0] d;
    d = {$urandom, $urandom, $urandom, $urandom};
    return {d, ref_crc(d)};
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive bits at negedge; returns at the negedge after the final bit
  task automatic drive_bits(input logic [FW-1:0] f, input int nbits,
                            input int gap_pct, input int junk, output bit early_done);
    early_done = 1'b0;
    for (int j = 0; j < junk; j++) begin
      start = 1'b0; valid = 1'b1; bin = 1'($urandom);
      @(negedge clk);
      if (done_o) early_done = 1'b1;
    end
    for (int i = 0; i < nbits; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        start = 1'($urandom); valid = 1'b0; bin = 1'($urandom);
        @(negedge clk);
        if (done_o) early_done = 1'b1;
      end
      start = (i == 0); valid = 1'b1; bin = f[FW-1-i];
      @(negedge clk);
      if (i < nbits - 1 && done_o) early_done = 1'b1;
    end
    start = 1'b0; valid = 1'b0; bin = 1'b0;
  endtask

  task automatic run_frame(input logic [FW-1:0] f, input string req,
                           input int gap_pct, input int junk, output int kind);
    logic [DW-1:0] ed;
    bit early;
    kind = classify(f, ed);
    drive_bits(f, FW, gap_pct, junk, early);
    check(!early, "R4", "done before last bit", 128'(early), 128'(0));
    check(done_o === 1'b1, "R4", "done after last bit", 128'(done_o), 128'(1));
    check({ok_o, corrected_o, chk_err_o, uncorr_o} ===
          {kind == 0, kind == 1, kind == 2, kind == 3}, req, "flags ok/fix/chk/bad",
          128'({ok_o, corrected_o, chk_err_o, uncorr_o}),
          128'({kind == 0, kind == 1, kind == 2, kind == 3}));
    check(data_o === ed, req, "data", data_o, ed);
    @(negedge clk);
    check(done_o === 1'b0 && ok_o === 1'b0 && corrected_o === 1'b0 &&
          chk_err_o === 1'b0 && uncorr_o === 1'b0, "R4", "pulse width",
          128'({done_o, ok_o, corrected_o, chk_err_o, uncorr_o}), 128'(0));
  endtask

  initial begin
    logic [FW-1:0] f, g;
    int k;
    bit early;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check(data_o === '0 && {done_o, ok_o, corrected_o, chk_err_o, uncorr_o} === 5'b0,
          "R1", "in reset", data_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_o === '0 && {done_o, ok_o, corrected_o, chk_err_o, uncorr_o} === 5'b0,
          "R1", "after reset", data_o, '0);

    // R5 clean frames, including all-zero and all-one payloads (R3 CRC)
    run_frame({{DW{1'b0}}, ref_crc('0)}, "R5", 0, 0, k);
    run_frame({{DW{1'b1}}, ref_crc('1)}, "R5", 0, 0, k);
    for (int n = 0; n < 3; n++) run_frame(rand_frame(), "R5", 0, 0, k);

    // R6/R7 every single position
    for (int p = 0; p < FW; p++) begin
      f = rand_frame();
      f[p] = ~f[p];
      run_frame(f, (p >= CW) ? "R6" : "R7", 0, 0, k);
      check(k == ((p >= CW) ? 1 : 2), (p >= CW) ? "R6" : "R7", "model class",
            128'(k), 128'((p >= CW) ? 1 : 2));
    end

    // R8/R9 two-bit errors never repaired
    for (int n = 0; n < 40; n++) begin
      int a, b;
      f = rand_frame();
      a = $urandom_range(FW - 1);
      do b = $urandom_range(FW - 1); while (b == a);
      f[a] = ~f[a]; f[b] = ~f[b];
      run_frame(f, "R9", 0, 0, k);
      if (corrected_o === 1'b1 || chk_err_o === 1'b1)
        $display("alias on double error at %0d,%0d", a, b);
      check(k == 3, "R9", "double model bad", 128'(k), 128'(3));
    end

    // R9 triple errors never reported clean; R8 checked against the model
    for (int n = 0; n < 10; n++) begin
      f = rand_frame();
      for (int t = 0; t < 3; t++) begin
        int a;
        a = (t * 48) + int'($urandom_range(47));
        f[a] = ~f[a];
      end
      run_frame(f, "R8", 0, 0, k);
      check(k != 0, "R9", "odd error not clean", 128'(k), 128'(3));
    end

    // R2 stalls with start toggling while valid is low, and stray bits before start
    for (int n = 0; n < 4; n++) begin
      f = rand_frame();
      if (n[0]) f[70] = ~f[70];
      run_frame(f, "R2", 30, 0, k);
    end
    run_frame(rand_frame(), "R2", 0, 25, k);
    f = rand_frame(); f[3] = ~f[3];
    run_frame(f, "R2", 10, 9, k);

    // R10 restart mid-frame
    g = rand_frame();
    drive_bits(g, 60, 0, 0, early);
    f = rand_frame(); f[100] = ~f[100];
    run_frame(f, "R10", 0, 0, k);
    check(!early, "R10", "no done for dropped frame", 128'(early), 128'(0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule